// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

Each processor carries its own copy of this timer. A cycle counter, 32 or 64 bits wide, starts at zero and advances by one on every clock. A 32-bit compare register sits next to it. Both share a single register address. A read at that address returns the counter and a write loads the compare register. Software cannot load the counter and cannot read the compare value back.

When the counter steps onto a value whose low 32 bits equal the compare register, the timer latches an interrupt request. The request stays latched until software acknowledges it. A mask bit decides whether a latched request reaches the interrupt output. To set a deadline, software reads the counter, adds an interval and writes the sum. If the sum is already behind the counter, the next match comes only after the low 32 bits wrap around.

Copies of the timer in different processors run on their own and are not kept in step with one another.

Top module: `itmr_top`

## Requirements
- R1: After reset, `reg_rdata` reads 0, the compare register holds 0, the mask is set (interrupt blocked), nothing is pending and `irq` is 0. Reset itself never causes an interrupt.
- R2: In every clock cycle after reset, the counter advances by exactly 1, modulo 2^CNT_W. CNT_W is 32 or 64.
- R3: `reg_rdata` always shows the counter. A write (`reg_wr`=1) loads `reg_wdata` into the compare register and does not change the count sequence.
- R4: A match event occurs in the first cycle in which the low 32 bits of the counter equal the compare register. At the clock edge that ends that cycle, the pending flag is set.
- R5: A compare value the counter has already passed produces no interrupt until the low 32 bits wrap around. This includes a value equal to the count seen in the cycle of the write.
- R6: The pending flag is sticky. It is cleared only at a clock edge where `irq_ack`=1 and no new match event occurs.
- R7: `irq` is 1 exactly when a request is pending and the mask is clear. A mask write (`mask_wr`=1 loads `mask_wdata`, where 1 means masked) does not change the pending flag.
- R8: If a match event and `irq_ack` fall in the same cycle, the match wins and the flag stays set.
- R9: A single equality produces one event. The event lasts one cycle and does not repeat while the equality persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the shared timer address |
| reg_wdata | input | 32 | New compare value |
| reg_rdata | output | CNT_W | Current counter value |
| mask_wr | input | 1 | Write strobe for the mask bit |
| mask_wdata | input | 1 | New mask value, 1 = masked |
| irq_ack | input | 1 | Write-one-to-clear pulse for the pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle and cover four properties:
- the counter steps by one,
- a match event always sets the pending flag,
- the flag holds until an acknowledge arrives with no new event,
- an event never lasts two cycles.

Only the bench scenarios can show the timing of a match against a deadline written at a chosen offset from the counter. The same applies to whether a value already passed, or equal to the current count, stays silent. The bench also covers masking and unmasking an already latched request, and an acknowledge that lands in the same cycle as a match.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned CMP_W = 32;

  function automatic logic [63:0] count_step(input logic [63:0] cur);
    return cur + 64'd1;
  endfunction

  function automatic logic low_equal(input logic [CMP_W-1:0] cnt_lo,
                                     input logic [CMP_W-1:0] cmp);
    return cnt_lo == cmp;
  endfunction
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q
);
  logic [63:0] wide_cur;
  logic [63:0] wide_nxt;

  generate
    if (CNT_W < 64) begin : g_pad
      assign wide_cur = {{(64-CNT_W){1'b0}}, cnt_q};
    end else begin : g_full
      assign wide_cur = cnt_q[63:0];
    end
  endgenerate

  assign wide_nxt = itmr_pkg::count_step(wide_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= wide_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/itmr_compare.sv
module itmr_compare #(
  parameter int unsigned CMP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMP_W-1:0] load_val,
  input  logic [CMP_W-1:0] cnt_lo,
  output logic             hit_evt
);
  logic [CMP_W-1:0] cmp_q;
  logic             eq_now;
  logic             eq_q;

  assign eq_now  = itmr_pkg::low_equal(cnt_lo, cmp_q);
  assign hit_evt = eq_now && !eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      eq_q  <= 1'b1;
    end else begin
      if (load) cmp_q <= load_val;
      eq_q <= eq_now;
    end
  end
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic ack,
  input  logic mask_wr,
  input  logic mask_wdata,
  output logic pend_q,
  output logic mask_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (hit_evt)  pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
      if (mask_wr)  mask_q <= mask_wdata;
    end
  end

  assign irq = pend_q && !mask_q;
endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  input  logic             irq_ack,
  output logic             irq
);
  localparam int unsigned CMP_W = itmr_pkg::CMP_W;

  logic [CNT_W-1:0] cnt_q;
  logic             hit_evt;
  logic             pend_q;
  logic             mask_q;

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q)
  );

  itmr_compare #(.CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .load_val(reg_wdata),
    .cnt_lo(cnt_q[CMP_W-1:0]), .hit_evt(hit_evt)
  );

  itmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .ack(irq_ack),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
  );

  assign reg_rdata = cnt_q;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] reg_rdata,
  input logic             irq_ack,
  input logic             hit_evt,
  input logic             pend_q
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> reg_rdata == $past(reg_rdata) + 1'b1); // R2
  AST_HIT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> pend_q); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_ack) |=> pend_q); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !hit_evt) |=> !pend_q); // R6
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> !hit_evt); // R9
endmodule

bind itmr_top itmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
  .hit_evt(hit_evt), .pend_q(pend_q)
);

// File: tb/itmr_top_test.sv
module itmr_top_test;
  localparam int unsigned CNT_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             mask_wr = 1'b0;
  logic             mask_wdata = 1'b0;
  logic             irq_ack = 1'b0;
  logic             irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  itmr_top #(.CNT_W(CNT_W)) uut (.*);

  // Bench-side reference built from the requirements
  logic [CNT_W-1:0] m_cnt;
  logic [31:0]      m_cmp;
  logic             m_prev_eq, m_pend, m_mask;
  logic             m_hit;
  assign m_hit = (m_cnt[31:0] == m_cmp) && !m_prev_eq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '0; m_prev_eq <= 1'b1; m_pend <= 1'b0; m_mask <= 1'b1;
    end else begin
      m_cnt     <= m_cnt + 1'b1;
      m_prev_eq <= (m_cnt[31:0] == m_cmp);
      if (reg_wr)  m_cmp <= reg_wdata;
      if (m_hit)        m_pend <= 1'b1;
      else if (irq_ack) m_pend <= 1'b0;
      if (mask_wr) m_mask <= mask_wdata;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mask(input logic v);
    mask_wr = 1'b1; mask_wdata = v; cyc(1); mask_wr = 1'b0;
  endtask

  task automatic ack;
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  // {signed offset from current count, cycles to watch}
  localparam logic [23:0] VEC [6] = '{
    {16'sd1,  8'd6},
    {16'sd4,  8'd8},
    {16'sd10, 8'd14},
    {16'sd0,  8'd12},
    {-16'sd3, 8'd12},
    {16'sd2,  8'd5}
  };

  initial begin
    cyc(3);
    // R1: reset values
    check("R1 rdata", reg_rdata, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R2 count after 1 edge", reg_rdata, 1);
    set_mask(1'b0);
    cyc(2);
    check("R1 no pending from reset", irq, 0);
    check("R2 count", reg_rdata, m_cnt);

    foreach (VEC[k]) begin
      logic signed [15:0] off;
      logic [7:0] wt;
      logic fired;
      off = VEC[k][23:8];
      wt = VEC[k][7:0];
      ack;
      check("R6 cleared", irq, 0);
      reg_wr = 1'b1;
      reg_wdata = m_cnt[31:0] + {{16{off[15]}}, off};
      cyc(1);
      reg_wr = 1'b0;
      fired = 1'b0;
      for (int j = 0; j < wt; j++) begin
        check(off > 0 ? "R4 match timing" : "R5 passed value silent", irq, m_pend & ~m_mask);
        check("R3 read counter", reg_rdata, m_cnt);
        fired |= irq;
        cyc(1);
      end
      check(off > 0 ? "R4 fired" : "R5 none", fired, off > 0);
    end

    // R7: masking hides but keeps pending
    ack;
    set_mask(1'b1);
    reg_wr = 1'b1; reg_wdata = m_cnt[31:0] + 32'd2; cyc(1); reg_wr = 1'b0;
    cyc(4);
    check("R7 masked", irq, 0);
    set_mask(1'b0);
    check("R7 unmask shows pending", irq, 1);
    cyc(3);
    check("R6 sticky", irq, 1);

    // R8: ack in the same cycle as a match
    reg_wr = 1'b1; reg_wdata = m_cnt[31:0] + 32'd3; cyc(1); reg_wr = 1'b0;
    cyc(2);
    irq_ack = 1'b1;
    check("R8 hit this cycle", m_hit, 1);
    cyc(1);
    irq_ack = 1'b0;
    check("R8 match wins over ack", irq, 1);
    ack;
    check("R6 ack clears", irq, 0);
    cyc(4);
    check("R9 no repeat event", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule